// File: doc/BRIEF.md
# SRAM Sleep Mode Controller

This block sits beside the array controller of a synchronous SRAM and takes it into and out of a low-power snooze state. The sleep request comes in asynchronously. It passes through a short synchronizer and then drives a four-phase sequencer: awake, entering, asleep and exiting. Entry and exit each last a fixed number of clock cycles. From the first cycle of entry until recovery ends, the controller holds an access-inhibit line high. The array controller treats every cycle in that span as a deselect, so stored data is never disturbed while the part is asleep.

Accesses that are still pending when entry starts are dropped. On the first entry cycle the controller sends a one-cycle flush pulse, and the inhibit line stops any later write commit. While the part is entering or asleep, a separate output forces the data pins to three-state.

The controller also watches the protocol. A request is a violation if it arrives while the chip is fully selected. An asserted enable is also a violation if it appears during the recovery window that follows release of the request. In either case the controller raises a one-cycle violation flag.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: The request passes through a two-flop synchronizer. A request that is high before clock edge k starts entry at edge k+2, so inhibit_o and flush_o are first seen high after edge k+2.
- R2: The entering phase lasts ENTRY_CYCLES cycles (2 by default). After that, sleep_o rises and stays high while the synchronized request stays high.
- R3: When the synchronized request falls while asleep, sleep_o drops at the next edge. The exiting phase then lasts EXIT_CYCLES cycles (2 by default), after which the block is awake.
- R4: inhibit_o is high in the entering, asleep and exiting phases. It is low only when the block is awake.
- R5: hiz_o is high in the entering and asleep phases, and low while exiting or awake.
- R6: flush_o is a single-cycle pulse in the first cycle of the entering phase.
- R7: If all enable bits of ce_act_i (bit = 1 means that enable is asserted) are 1 at the edge where entry starts, viol_o is high for the following cycle. A partial selection at that edge does not raise viol_o.
- R8: If any bit of ce_act_i is 1 at an edge where the block is in the exiting phase, viol_o is high for the following cycle.
- R9: ce_act_i is ignored while awake with no request and while asleep. In those cases it causes no violation and no phase change.
- R10: If the synchronized request falls during the entering phase, entry is abandoned. The block goes through a full exiting phase before it returns to awake.
- R11: An asynchronous reset (rst_ni low) forces the awake phase, with all outputs low, and clears the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| ce_act_i | input | NUM_CE | Chip enables, decoded to active-high |
| sleep_o | output | 1 | Array is in the snooze state |
| inhibit_o | output | 1 | Treat this cycle as a deselect |
| hiz_o | output | 1 | Force data pins to three-state |
| flush_o | output | 1 | Discard pending accesses |
| viol_o | output | 1 | Protocol violation, one cycle |

## Verification
The bench targets the edge where entry begins, because the two synchronizer stages and the counter offset are easy to get wrong by one. A design that is off by one would move the flush pulse and the rise of sleep_o by a cycle. It also checks that a partial selection at entry is accepted while a full selection is flagged. A design with the wrong reduction would flag both cases or neither. The recovery window is probed with a single enable bit, and enables are also driven while the block is asleep, which would catch a window that is too long or too short. A request that drops mid-entry must still pass through the exiting phase; a design that skips straight to awake would drop inhibit_o early.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;
  typedef enum logic [1:0] {
    PH_AWAKE    = 2'd0,
    PH_ENTERING = 2'd1,
    PH_ASLEEP   = 2'd2,
    PH_EXITING  = 2'd3
  } sleep_phase_e;
endpackage

// File: rtl/sleep_req_sync.sv
module sleep_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 1'b0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sleep_phase_cnt.sv
module sleep_phase_cnt #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  // saturating: never wraps back to zero without a clear
  p_cnt_no_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o != '0) |=> (cnt_o != '0));
endmodule

// File: rtl/sleep_viol_chk.sv
module sleep_viol_chk #(
  parameter int NUM_CE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              entry_start_i,
  input  logic              in_recovery_i,
  input  logic [NUM_CE-1:0] ce_act_i,
  output logic              viol_o
);
  logic selected, any_en;

  assign selected = &ce_act_i;
  assign any_en   = |ce_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_o <= 1'b0;
    else viol_o <= (entry_start_i && selected) || (in_recovery_i && any_en);
  end

  // R7/R8: a flag always has a cause in the previous cycle
  p_viol_has_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(entry_start_i || in_recovery_i));
  p_recovery_enable_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_recovery_i && any_en) |=> viol_o);
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
  import sram_sleep_pkg::*;
#(
  parameter int NUM_CE       = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic [NUM_CE-1:0] ce_act_i,
  output logic              sleep_o,
  output logic              inhibit_o,
  output logic              hiz_o,
  output logic              flush_o,
  output logic              viol_o
);
  localparam int MAX_CYC = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CW      = $clog2(MAX_CYC) + 1;
  localparam logic [CW-1:0] ENT_LAST = CW'(ENTRY_CYCLES - 1);
  localparam logic [CW-1:0] EXT_LAST = CW'(EXIT_CYCLES - 1);

  sleep_phase_e phase_q, phase_d;
  logic         req_s;
  logic         cnt_clr;
  logic         entry_start;
  logic         flush_q;
  logic [CW-1:0] cnt;

  sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_s)
  );

  sleep_phase_cnt #(.W(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  always_comb begin
    phase_d     = phase_q;
    cnt_clr     = 1'b0;
    entry_start = 1'b0;
    unique case (phase_q)
      PH_AWAKE: if (req_s) begin
        phase_d     = PH_ENTERING;
        cnt_clr     = 1'b1;
        entry_start = 1'b1;
      end
      PH_ENTERING: begin
        if (!req_s) begin
          phase_d = PH_EXITING;   // abandoned entry still recovers
          cnt_clr = 1'b1;
        end else if (cnt == ENT_LAST) begin
          phase_d = PH_ASLEEP;
        end
      end
      PH_ASLEEP: if (!req_s) begin
        phase_d = PH_EXITING;
        cnt_clr = 1'b1;
      end
      PH_EXITING: if (cnt == EXT_LAST) phase_d = PH_AWAKE;
      default: phase_d = PH_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AWAKE;
      flush_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      flush_q <= entry_start;
    end
  end

  sleep_viol_chk #(.NUM_CE(NUM_CE)) u_viol (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .entry_start_i(entry_start),
    .in_recovery_i(phase_q == PH_EXITING),
    .ce_act_i     (ce_act_i),
    .viol_o       (viol_o)
  );

  assign sleep_o   = (phase_q == PH_ASLEEP);
  assign inhibit_o = (phase_q != PH_AWAKE);
  assign hiz_o     = (phase_q == PH_ENTERING) || (phase_q == PH_ASLEEP);
  assign flush_o   = flush_q;

  p_sleep_inhibited_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> inhibit_o);
  p_hiz_inside_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> inhibit_o);
  p_flush_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  p_flush_opens_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inhibit_o) |-> flush_o);
  p_sleep_after_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(phase_q == PH_ENTERING));
  p_exit_passes_recovery_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inhibit_o) |-> $past(phase_q == PH_EXITING));
  p_asleep_no_viol_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_q == PH_ASLEEP) |-> !viol_o);
endmodule

// File: tb/sram_sleep_ctrl_bench.sv
module sram_sleep_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_req_i = 1'b0;
  logic [2:0] ce_act_i = 3'b000;
  logic       sleep_o, inhibit_o, hiz_o, flush_o, viol_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  sram_sleep_ctrl u_sram_sleep_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .ce_act_i   (ce_act_i),
    .sleep_o    (sleep_o),
    .inhibit_o  (inhibit_o),
    .hiz_o      (hiz_o),
    .flush_o    (flush_o),
    .viol_o     (viol_o)
  );

  // {req, ce[2:0], sleep, inhibit, hiz, flush, viol}; outputs after the edge
  localparam int NV = 32;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_000_00000, 9'b1_000_00000, 9'b1_000_00000, 9'b1_000_01110, // R1 R6
    9'b1_000_01100, 9'b1_000_11100, 9'b0_111_11100, 9'b0_000_11100, // R2 R9
    9'b0_000_01000, 9'b0_000_01000, 9'b0_000_00000, 9'b1_111_00000, // R3 R5
    9'b1_111_00000, 9'b1_111_01111, 9'b1_000_01100, 9'b0_000_11100, // R7
    9'b0_000_11100, 9'b0_000_01000, 9'b0_010_01001, 9'b0_000_00000, // R8
    9'b0_111_00000, 9'b1_000_00000, 9'b0_000_00000, 9'b0_000_01110, // R9
    9'b0_000_01000, 9'b0_000_01000, 9'b0_000_00000, 9'b1_001_00000, // R10
    9'b1_001_00000, 9'b1_001_01110, 9'b1_000_01100, 9'b1_000_11100  // R7 partial
  };

  function automatic string vec_tag(int i);
    if (i < 4)       return "R1";
    else if (i < 8)  return "R2";
    else if (i < 11) return "R3";
    else if (i < 16) return "R7";
    else if (i < 20) return "R8";
    else if (i < 22) return "R9";
    else if (i < 27) return "R10";
    else             return "R7";
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sleep,inh,hiz,flush,viol} actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #1;
    chk("R11 reset", {sleep_o, inhibit_o, hiz_o, flush_o, viol_o}, 5'b00000);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      sleep_req_i = VEC[i][8];
      ce_act_i    = VEC[i][7:5];
      @(posedge clk_i);
      @(negedge clk_i);
      chk(vec_tag(i), {sleep_o, inhibit_o, hiz_o, flush_o, viol_o}, VEC[i][4:0]);
    end
    // asleep now; R11 asynchronous reset mid-sleep
    rst_ni = 1'b0;
    #1;
    chk("R11 async reset", {sleep_o, inhibit_o, hiz_o, flush_o, viol_o}, 5'b00000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sleep_req_i = 1'b1;
    ce_act_i = 3'b000;
    // synchronizer cleared by reset: two edges before entry (R1 R11)
    @(posedge clk_i); @(negedge clk_i);
    chk("R11 sync cleared", {sleep_o, inhibit_o, hiz_o, flush_o, viol_o}, 5'b00000);
    @(posedge clk_i); @(negedge clk_i);
    chk("R1 not yet", {sleep_o, inhibit_o, hiz_o, flush_o, viol_o}, 5'b00000);
    @(posedge clk_i); @(negedge clk_i);
    chk("R6 flush after reset", {sleep_o, inhibit_o, hiz_o, flush_o, viol_o}, 5'b01110);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule